// File: doc/BRIEF.md
# Reference-versus-target error monitor

This block sits beside two copies of a pattern recognizer during a fault-injection run. One copy is left fault-free and acts as the reference. The other is the target that receives injected faults. Each copy raises a match pulse when it recognizes its key. The monitor records whether each copy raised a match at any point during a pattern window. When the compare strobe marks the end of the window, the monitor compares the two results.

If the reference matched and the target did not, the window is a miss. If the target matched and the reference did not, the window is a false hit. The mode input on the strobe cycle says whether the run injects one fault or two at a time, and this decides which pair of counters receives the error.

There are four saturating counters. When any of them reaches its top value the monitor raises a sticky halted flag. From then on every counter holds still until reset, so no category can wrap around.

Top module: `err_tally_monitor`

## Requirements
- R1: After reset all four counters read 0 and `halted` is 0.
- R2: At a strobe with `dbl_mode`=0, a window in which the reference matched and the target did not increments `single_miss` by one, at the clock edge that samples the strobe.
- R3: At a strobe with `dbl_mode`=0, a window in which the target matched and the reference did not increments `single_false` by one.
- R4: At a strobe with `dbl_mode`=1, the same two kinds of error go to `double_miss` and `double_false`, and the single-fault counters do not change.
- R5: A window in which both recognizers matched, or neither did, changes no counter.
- R6: A match counts for its window if it is high on any cycle of the window, the strobe cycle included. So the two matches may arrive on different cycles of the same window without an error being counted.
- R7: The match record clears at every strobe. A match seen in one window has no effect on the next window.
- R8: `halted` goes to 1 at the same edge at which any counter reaches 255 (all ones), and it stays 1 until reset.
- R9: While `halted` is 1, no counter changes, whatever the inputs.
- R10: Counters change only at an edge that samples a strobe, by exactly +1, and at most one counter changes per strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_match | input | 1 | Match pulse of the fault-free recognizer |
| tgt_match | input | 1 | Match pulse of the recognizer under test |
| window_end | input | 1 | Compare strobe, high on the last cycle of each pattern window |
| dbl_mode | input | 1 | 1 = double-fault run, 0 = single-fault run, sampled with the strobe |
| single_miss | output | CNT_W | Misses counted in single-fault runs |
| single_false | output | CNT_W | False hits counted in single-fault runs |
| double_miss | output | CNT_W | Misses counted in double-fault runs |
| double_false | output | CNT_W | False hits counted in double-fault runs |
| halted | output | 1 | Sticky flag: some counter has reached its top value |

## Verification
The properties take for granted two things about the inputs: the strobe closes every window, and `dbl_mode` is meaningful on the strobe cycle. Reset is the only way out of the halted state.

The stimulus builds windows of one to six cycles, each closed by exactly one strobe. Match pulses are placed at random cycles, including the strobe cycle itself. The mode changes only between windows.

A directed run of 255 consecutive misses drives one counter to saturation. It then keeps supplying errors of every kind, which exercises the freeze.

// File: rtl/err_tally_monitor.sv
module err_tally_monitor #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_match,
  input  logic             tgt_match,
  input  logic             window_end,
  input  logic             dbl_mode,
  output logic [CNT_W-1:0] single_miss,
  output logic [CNT_W-1:0] single_false,
  output logic [CNT_W-1:0] double_miss,
  output logic [CNT_W-1:0] double_false,
  output logic             halted
);
  localparam logic [CNT_W-1:0] TOP  = '1;
  localparam logic [CNT_W-1:0] NEAR = TOP - 1'b1;

  logic ref_seen, tgt_seen;
  logic ref_any, tgt_any, judge, miss, fhit;
  logic inc_sm, inc_sf, inc_dm, inc_df, sat_hit;

  assign ref_any = ref_seen | ref_match;
  assign tgt_any = tgt_seen | tgt_match;
  assign judge   = window_end & ~halted;
  assign miss    = judge & ref_any & ~tgt_any;
  assign fhit    = judge & tgt_any & ~ref_any;

  assign inc_sm = miss & ~dbl_mode;
  assign inc_sf = fhit & ~dbl_mode;
  assign inc_dm = miss &  dbl_mode;
  assign inc_df = fhit &  dbl_mode;

  assign sat_hit = (inc_sm && single_miss  == NEAR) ||
                   (inc_sf && single_false == NEAR) ||
                   (inc_dm && double_miss  == NEAR) ||
                   (inc_df && double_false == NEAR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_seen <= 1'b0;
      tgt_seen <= 1'b0;
    end else if (window_end) begin
      ref_seen <= 1'b0;
      tgt_seen <= 1'b0;
    end else begin
      ref_seen <= ref_any;
      tgt_seen <= tgt_any;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      single_miss  <= '0;
      single_false <= '0;
      double_miss  <= '0;
      double_false <= '0;
      halted       <= 1'b0;
    end else begin
      if (inc_sm) single_miss  <= single_miss  + 1'b1;
      if (inc_sf) single_false <= single_false + 1'b1;
      if (inc_dm) double_miss  <= double_miss  + 1'b1;
      if (inc_df) double_false <= double_false + 1'b1;
      if (sat_hit) halted <= 1'b1;
    end
  end
endmodule

module err_tally_monitor_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_match,
  input logic             tgt_match,
  input logic             window_end,
  input logic             dbl_mode,
  input logic [CNT_W-1:0] single_miss,
  input logic [CNT_W-1:0] single_false,
  input logic [CNT_W-1:0] double_miss,
  input logic [CNT_W-1:0] double_false,
  input logic             halted
);
  logic [4*CNT_W-1:0] all_cnt;
  assign all_cnt = {single_miss, single_false, double_miss, double_false};

  p_reset_r1: assert property (@(posedge clk) !rst_n |=> (all_cnt == '0 && !halted));
  p_agree_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (window_end && ref_match && tgt_match) |=> $stable(all_cnt));
  p_dbl_keeps_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (window_end && dbl_mode) |=> ($stable(single_miss) && $stable(single_false)));
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n) halted |=> halted);
  p_top_halts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (single_miss == '1 || single_false == '1 || double_miss == '1 || double_false == '1) |-> halted);
  p_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n) halted |=> $stable(all_cnt));
  p_only_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !window_end |=> $stable(all_cnt));
  p_one_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    window_end |=> ($countones({single_miss != $past(single_miss), single_false != $past(single_false),
                                double_miss != $past(double_miss), double_false != $past(double_false)}) <= 1));
  p_inc_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
    window_end |=> (single_miss == $past(single_miss) || single_miss == $past(single_miss) + 1'b1));
endmodule

bind err_tally_monitor err_tally_monitor_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_err_tally_monitor.sv
module tb_err_tally_monitor;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_match = 1'b0, tgt_match = 1'b0, window_end = 1'b0, dbl_mode = 1'b0;
  logic [7:0] single_miss, single_false, double_miss, double_false;
  logic halted;
  int checks = 0, errors = 0;
  logic [7:0] m_cnt [4];
  logic m_halt, m_ref, m_tgt;

  always #10ns clk = ~clk;

  err_tally_monitor #(.CNT_W(8)) dut (.*);

  function automatic int pick(input logic fn, input logic dm);
    return (dm ? 2 : 0) + (fn ? 0 : 1);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic compare_all(input string req);
    chk(req, {24'd0, single_miss}, {24'd0, m_cnt[0]});
    chk(req, {24'd0, single_false}, {24'd0, m_cnt[1]});
    chk(req, {24'd0, double_miss}, {24'd0, m_cnt[2]});
    chk(req, {24'd0, double_false}, {24'd0, m_cnt[3]});
    chk(req, {31'd0, halted}, {31'd0, m_halt});
  endtask

  task automatic model_reset();
    for (int i = 0; i < 4; i++) m_cnt[i] = 8'd0;
    m_halt = 1'b0; m_ref = 1'b0; m_tgt = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ref_match = 0; tgt_match = 0; window_end = 0; dbl_mode = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    model_reset();
  endtask

  task automatic cyc(input logic r, input logic t, input logic we, input logic dm, input string req);
    logic ra, ta;
    int k;
    ref_match = r; tgt_match = t; window_end = we; dbl_mode = dm;
    @(posedge clk);
    #1;
    ra = m_ref | r; ta = m_tgt | t;
    if (we) begin
      if (!m_halt && (ra != ta)) begin
        k = pick(ra, dm);
        m_cnt[k] = m_cnt[k] + 8'd1;
        if (m_cnt[k] == 8'hFF) m_halt = 1'b1;
      end
      m_ref = 1'b0; m_tgt = 1'b0;
      compare_all(req);
    end else begin
      m_ref = ra; m_tgt = ta;
    end
  endtask

  task automatic window(input int len, input logic [5:0] rmask, input logic [5:0] tmask,
                        input logic dm, input string req);
    for (int c = 0; c < len; c++) cyc(rmask[c], tmask[c], c == len - 1, dm, req);
  endtask

  initial begin
    #(20ns * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    #1 compare_all("R1 reset");
    window(3, 6'b000010, 6'b000000, 1'b0, "R2 single miss");
    window(3, 6'b000000, 6'b000100, 1'b0, "R3 single false hit");
    window(2, 6'b000001, 6'b000000, 1'b1, "R4 double miss");
    window(4, 6'b000000, 6'b001000, 1'b1, "R4 double false hit");
    window(3, 6'b000010, 6'b000010, 1'b0, "R5 both matched");
    window(3, 6'b000000, 6'b000000, 1'b1, "R5 neither matched");
    window(4, 6'b000001, 6'b000010, 1'b0, "R6 one-cycle skew");
    window(4, 6'b001000, 6'b000001, 1'b0, "R6 match on strobe cycle");
    window(3, 6'b000101, 6'b000001, 1'b0, "R7 window before");
    window(3, 6'b000000, 6'b000010, 1'b0, "R7 fresh window false hit");
    window(1, 6'b000001, 6'b000000, 1'b0, "R2 one-cycle window");
    for (int w = 0; w < 400; w++) begin
      int len;
      len = 1 + int'($urandom % 6);
      window(len, 6'($urandom), 6'($urandom), 1'($urandom), "R10 random windows");
    end
    do_reset();
    for (int w = 0; w < 254; w++) window(1, 6'b1, 6'b0, 1'b0, "R8 approach top");
    chk("R8 not halted at 254", {31'd0, halted}, 32'd0);
    window(2, 6'b01, 6'b00, 1'b0, "R8 reach top");
    chk("R8 halted at 255", {31'd0, halted}, 32'd1);
    window(2, 6'b00, 6'b01, 1'b0, "R9 frozen single false");
    window(2, 6'b01, 6'b00, 1'b1, "R9 frozen double miss");
    window(2, 6'b00, 6'b10, 1'b1, "R9 frozen double false");
    for (int w = 0; w < 20; w++)
      window(2, 6'($urandom), 6'($urandom), 1'($urandom), "R9 frozen random");
    chk("R8 halted sticky", {31'd0, halted}, 32'd1);
    chk("R9 counter held", {24'd0, single_miss}, 32'd255);
    do_reset();
    #1 compare_all("R1 reset after halt");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule